// File: doc/BRIEF.md
# Converter Result Byte Multiplexer

This block sits between a 16-bit converter and a narrow 8-bit output bus. Each converter result arrives with a small channel tag. The block delays the result by a fixed number of converter clock cycles, which models the conversion pipeline. It then presents the result on the byte bus. In the default mode each result takes two bus beats: the upper byte while the converter clock is high and the lower byte while it is low. In the other mode only the upper byte is shown, for the whole converter period. The bus is released to high impedance whenever the active-low enable input is high.

Everything runs on one fast system clock, `clk`. The converter clock `adcClk` is a level input, and the block samples it on `clk`. A rising edge of the sampled level starts a new converter period. On that edge the pipeline advances one step and the input word is captured. Two further controls are available. An extra-delay control holds every bus beat back by one system clock. A power-down control freezes the bus at its current value and stops new results from entering the pipeline.

Top module: `adc_byte_mux`

## Requirements
- R1: After reset, and until the first result leaves the pipeline, `dataOut`, `outTag` and `outHigh` are all zero when `oeN` is low.
- R2: A word and tag captured at converter advance number a are the held result from advance a+LATENCY (LATENCY = 9 by default). The held result changes only at an advance.
- R3: When `singleByte` is 0, `dataOut` carries bits 15..8 of the held word and `outHigh` = 1 while the sampled converter phase is high. It carries bits 7..0 with `outHigh` = 0 while that phase is low. Both bytes come from the same held word.
- R4: When `singleByte` is 1, `dataOut` carries bits 15..8 of the held word in both phases, and `outHigh` = 1.
- R5: When `oeN` is 1, all bits of `dataOut` are high impedance. `outTag` and `outHigh` are unaffected, and the pipeline keeps running.
- R6: When `extraDelay` is 1, `dataOut`, `outTag` and `outHigh` show the value they would have shown one `clk` cycle earlier without it.
- R7: From the first `clk` edge that samples `powerDown` high, the outputs hold the value they had just before that edge. No converter advance takes place while `powerDown` stays sampled high, so words offered during that time are never captured. When it is released, output resumes at the position where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| adcClk | input | 1 | Converter clock level; a sampled rising edge starts a new period |
| convWord | input | 16 | Converter result; held stable through the period it is offered in |
| convTag | input | 2 | Channel tag carried along with the result |
| singleByte | input | 1 | 1 = upper byte only; 0 = upper then lower byte |
| extraDelay | input | 1 | 1 = delay every bus beat by one clk cycle |
| powerDown | input | 1 | 1 = freeze outputs and stop capture |
| oeN | input | 1 | Active-low output enable for `dataOut` |
| dataOut | output | 8 | Byte bus; high impedance while `oeN` is 1 |
| outTag | output | 2 | Tag of the result currently on the bus |
| outHigh | output | 1 | 1 when `dataOut` carries the upper byte |

## Verification
An advance happens on the second `clk` edge after `adcClk` is driven high. The word offered in that period becomes the held result on the LATENCY-th advance after that. Its upper byte is then due from that same edge until the second edge after `adcClk` falls. Its lower byte follows until the next advance. The bench drives `adcClk` two cycles high and two cycles low. It samples on all four falling edges of each period and keeps its own list of accepted words, so it knows which word and which byte each sample must show. With the extra delay set, every expected beat moves one falling edge later. The first sample after a mode change is skipped, because it mixes the two settings. During power-down the bench expects the value seen on the falling edge just before the freeze took hold. It does not count the periods spent frozen as advances.

// File: rtl/adc_byte_mux_pkg.sv
package adc_byte_mux_pkg;

  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = BYTE_W * LANES;
  localparam int TAG_W  = 2;

  // one converter result travelling through the delay line
  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [WORD_W-1:0] word;
  } sample_t;

  // one bus beat as presented to the pins
  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic              high;
    logic [BYTE_W-1:0] data;
  } beat_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic advance;
    logic phaseHigh;
    logic freeze;
  } strobes_t;

endpackage

// File: rtl/adc_byte_mux_ctrl.sv
module adc_byte_mux_ctrl
  import adc_byte_mux_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     adcClk,
  input  logic     powerDown,
  output strobes_t strb
);

  logic adcQ;
  logic phaseQ;
  logic pdQ;

  // sample converter clock level, keep one more copy for edge and phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adcQ   <= 1'b0;
      phaseQ <= 1'b0;
      pdQ    <= 1'b0;
    end else begin
      adcQ   <= adcClk;
      phaseQ <= adcQ;
      pdQ    <= powerDown;
    end
  end

  always_comb begin
    strb.advance   = adcQ & ~phaseQ & ~pdQ;
    strb.phaseHigh = phaseQ;
    strb.freeze    = pdQ;
  end

endmodule

// File: rtl/adc_byte_mux_dp.sv
module adc_byte_mux_dp
  import adc_byte_mux_pkg::*;
#(
  parameter int LATENCY = 9
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [WORD_W-1:0] inWord,
  input  logic [TAG_W-1:0]  inTag,
  input  logic              singleByte,
  input  logic              extraDelay,
  output sample_t           heldSample,
  output beat_t             liveBeat,
  output beat_t             busBeat
);

  localparam int STAGES = LATENCY + 1;

  sample_t pipe [STAGES];

  // capture stage plus LATENCY delay stages, all advancing together
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else if (strb.advance) begin
      pipe[0] <= '{tag: inTag, word: inWord};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign heldSample = pipe[STAGES-1];

  // split the held word into byte lanes, lane LANES-1 is the upper byte
  logic [BYTE_W-1:0] lane [LANES];
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign lane[j] = heldSample.word[j*BYTE_W +: BYTE_W];
  end

  logic pickUpper;
  always_comb begin
    pickUpper     = singleByte | strb.phaseHigh;
    liveBeat.tag  = heldSample.tag;
    liveBeat.high = pickUpper;
    liveBeat.data = pickUpper ? lane[LANES-1] : lane[0];
  end

  beat_t dlyBeat;
  beat_t chosenBeat;
  beat_t frozenBeat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyBeat    <= '0;
      frozenBeat <= '0;
    end else if (!strb.freeze) begin
      dlyBeat    <= liveBeat;
      frozenBeat <= chosenBeat;
    end
  end

  assign chosenBeat = extraDelay  ? dlyBeat    : liveBeat;
  assign busBeat    = strb.freeze ? frozenBeat : chosenBeat;

endmodule

// File: rtl/adc_byte_mux.sv
module adc_byte_mux
  import adc_byte_mux_pkg::*;
#(
  parameter int LATENCY = 9
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              adcClk,
  input  logic [WORD_W-1:0] convWord,
  input  logic [TAG_W-1:0]  convTag,
  input  logic              singleByte,
  input  logic              extraDelay,
  input  logic              powerDown,
  input  logic              oeN,
  output logic [BYTE_W-1:0] dataOut,
  output logic [TAG_W-1:0]  outTag,
  output logic              outHigh
);

  strobes_t strb;
  sample_t  heldSample;
  beat_t    liveBeat;
  beat_t    busBeat;

  adc_byte_mux_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .adcClk    (adcClk),
    .powerDown (powerDown),
    .strb      (strb)
  );

  adc_byte_mux_dp #(.LATENCY(LATENCY)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .inWord     (convWord),
    .inTag      (convTag),
    .singleByte (singleByte),
    .extraDelay (extraDelay),
    .heldSample (heldSample),
    .liveBeat   (liveBeat),
    .busBeat    (busBeat)
  );

  assign dataOut = oeN ? {BYTE_W{1'bz}} : busBeat.data;
  assign outTag  = busBeat.tag;
  assign outHigh = busBeat.high;

endmodule

// File: rtl/adc_byte_mux_sva.sv
module adc_byte_mux_sva
  import adc_byte_mux_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input strobes_t         strb,
  input sample_t          heldSample,
  input beat_t            liveBeat,
  input logic             singleByte,
  input logic             extraDelay,
  input logic             powerDown,
  input logic [TAG_W-1:0] outTag,
  input logic             outHigh
);

  assert_hold_steady_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance |=> $stable(heldSample))
    else $error("held result changed without an advance");

  assert_phase_select_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!singleByte && !extraDelay && !$past(powerDown)) |-> (outHigh == strb.phaseHigh))
    else $error("byte choice does not follow converter phase");

  assert_upper_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    (singleByte && !extraDelay && !$past(powerDown)) |-> outHigh)
    else $error("lower byte shown in single-byte mode");

  assert_one_cycle_late_R6: assert property (@(posedge clk) disable iff (!rstN)
    (extraDelay && !$past(powerDown) && !$past(powerDown, 2)) |->
      ((outTag == $past(liveBeat.tag)) && (outHigh == $past(liveBeat.high))))
    else $error("delayed beat does not match previous live beat");

  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    (powerDown && $past(powerDown)) |=> ($stable(outTag) && $stable(outHigh)))
    else $error("outputs moved during power-down");

endmodule

bind adc_byte_mux adc_byte_mux_sva u_sva (
  .clk        (clk),
  .rstN       (rstN),
  .strb       (strb),
  .heldSample (heldSample),
  .liveBeat   (liveBeat),
  .singleByte (singleByte),
  .extraDelay (extraDelay),
  .powerDown  (powerDown),
  .outTag     (outTag),
  .outHigh    (outHigh)
);

// File: tb/adc_byte_mux_bench.sv
module adc_byte_mux_bench;
  import adc_byte_mux_pkg::*;

  localparam int LAT = 9;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        adcClk = 1'b0;
  logic [15:0] convWord = '0;
  logic [1:0]  convTag = '0;
  logic        singleByte = 1'b0;
  logic        extraDelay = 1'b0;
  logic        powerDown = 1'b0;
  logic        oeN = 1'b0;
  wire  [7:0]  dataOut;
  wire  [1:0]  outTag;
  wire         outHigh;

  int checks = 0;
  int fails = 0;
  int periodIdx = 0;
  int cyc = 0;
  bit done = 1'b0;

  sample_t     accArr [0:511];
  int          accCount = 0;
  sample_t     holdExp = '0;
  logic [10:0] frozenExp = '0;
  bit          prevPd = 1'b0;
  bit          modeChanged = 1'b0;

  adc_byte_mux #(.LATENCY(LAT)) u_adc_byte_mux (
    .clk(clk), .rstN(rstN), .adcClk(adcClk), .convWord(convWord), .convTag(convTag),
    .singleByte(singleByte), .extraDelay(extraDelay), .powerDown(powerDown), .oeN(oeN),
    .dataOut(dataOut), .outTag(outTag), .outHigh(outHigh)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual still running, expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // expected beat {tag, high, byte} for a held sample in a given phase
  function automatic logic [10:0] beatOf(sample_t s, bit phase);
    bit hi;
    hi = singleByte | phase;
    return {s.tag, hi, hi ? s.word[15:8] : s.word[7:0]};
  endfunction

  function automatic string reqFor(bit pd, bit late);
    if (pd) return "R7";
    if (oeN) return "R5";
    if (extraDelay) return "R6";
    if (singleByte) return "R4";
    return late ? "R2" : "R3";
  endfunction

  task automatic checkBeat(string req, string what, logic [10:0] exp);
    logic [7:0] expByte;
    expByte = oeN ? 8'hzz : exp[7:0];
    checks++;
    if (dataOut !== expByte || outTag !== exp[10:9] || outHigh !== exp[8]) begin
      fails++;
      $display("FAIL %s %s: actual data=%h tag=%0d high=%b expected data=%h tag=%0d high=%b",
               req, what, dataOut, outTag, outHigh, expByte, exp[10:9], exp[8]);
    end
  endtask

  // one converter period: two clk high, two clk low, sampled on each falling edge
  task automatic runPeriod(bit pd);
    sample_t     s;
    sample_t     oldHold;
    logic [10:0] e0;
    s.word  = 16'h3C5A ^ (16'(periodIdx) * 16'h1F37);
    s.tag   = 2'(periodIdx % 3);
    oldHold = holdExp;
    @(negedge clk);
    e0 = prevPd ? frozenExp : (extraDelay ? beatOf(oldHold, 1'b1) : beatOf(oldHold, 1'b0));
    if (!modeChanged) checkBeat(reqFor(prevPd, 1'b0), "s0", e0);
    modeChanged = 1'b0;
    if (pd && !prevPd) frozenExp = e0;
    adcClk = 1'b1; convWord = s.word; convTag = s.tag; powerDown = pd;
    @(negedge clk);
    checkBeat(reqFor(pd, 1'b0), "s1", pd ? frozenExp : beatOf(oldHold, 1'b0));
    if (!pd) begin
      holdExp = (accCount >= LAT) ? accArr[accCount-LAT] : '0;
      accArr[accCount] = s;
      accCount++;
    end
    @(negedge clk);
    checkBeat(reqFor(pd, 1'b1), "s2",
              pd ? frozenExp : (extraDelay ? beatOf(oldHold, 1'b0) : beatOf(holdExp, 1'b1)));
    adcClk = 1'b0;
    @(negedge clk);
    checkBeat(reqFor(pd, 1'b1), "s3", pd ? frozenExp : beatOf(holdExp, 1'b1));
    prevPd = pd;
    periodIdx++;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkBeat("R1", "in reset", 11'h000);
    rstN = 1'b1;
    @(negedge clk);
    checkBeat("R1", "after reset", 11'h000);
  endtask

  task automatic testTwoByte();
    repeat (14) runPeriod(1'b0);
  endtask

  task automatic testSingleByte();
    singleByte = 1'b1; modeChanged = 1'b1;
    repeat (4) runPeriod(1'b0);
    singleByte = 1'b0; modeChanged = 1'b1;
    runPeriod(1'b0);
  endtask

  task automatic testOutputEnable();
    oeN = 1'b1;
    repeat (2) runPeriod(1'b0);
    oeN = 1'b0;
    runPeriod(1'b0);
  endtask

  task automatic testExtraDelay();
    extraDelay = 1'b1; modeChanged = 1'b1;
    repeat (4) runPeriod(1'b0);
    singleByte = 1'b1; modeChanged = 1'b1;
    repeat (2) runPeriod(1'b0);
    singleByte = 1'b0; extraDelay = 1'b0; modeChanged = 1'b1;
    runPeriod(1'b0);
  endtask

  task automatic testPowerDown();
    repeat (3) runPeriod(1'b1);
    repeat (12) runPeriod(1'b0);
  endtask

  initial begin
    testReset();
    testTwoByte();
    testSingleByte();
    testOutputEnable();
    testExtraDelay();
    testPowerDown();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule